// File: doc/BRIEF.md
# Parallel-Port Bridge Register Sequencer

This block is a host-side master that performs one register read or one register write on a parallel-to-IDE bridge. It drives the port's data byte and its four control lines, and samples the port's status and data inputs. A single request gives a target select (task-file registers or command-set registers), a 3-bit register number, a read/write flag, a transfer style and write data. The block then plays out a fixed series of port writes and returns the read byte with a one-cycle done pulse.

Two transfer styles are supported. In the nibble style, writes are full bytes and reads collect the byte as two 4-bit halves from the status lines. In the byte style, both reads and writes use the full data byte, with the data lines turned around for the read. Every access starts with the same handshake: fixed bursts of control-line values wrapped around an address byte. Every port write is held for a number of clock cycles that is set at run time and latched when the request is accepted.

Top module: `ppreg_seq`

## Requirements
- R1: After a synchronous active-low reset, `ctl_o` is 4'h4, `pd_o` is 8'h00, and `pd_rev_o`, `busy_o` and `done_o` are 0.
- R2: The address byte placed on `pd_o` is `reg_i` times 4, plus 1, plus `cmd_sel_i` (0 selects task-file registers, 1 selects command-set registers).
- R3: Every access begins with the following steps: data 8'h01, burst P, address byte, burst Q, data 8'h00, burst P. Burst P drives `ctl_o` through 5,D,5,D,5,4. Burst Q drives it through 5,7,5,4. A data step leaves `ctl_o` unchanged, and a control step leaves `pd_o` unchanged. Between accesses `ctl_o` rests at 4'h4.
- R4: A write (`wr_i`=1, either style) then performs two rounds of "data = `wdata_i`, burst Q".
- R5: A nibble-style read (`wr_i`=0, `byte_mode_i`=0) then drives `ctl_o` to 6,4,6,4,6,4,6,4. The status byte is sampled at the end of the first 6 step (a) and at the end of the second 6 step (b). The result is {b[7:4], a[7:4]}.
- R6: A byte-style read (`wr_i`=0, `byte_mode_i`=1) then drives `ctl_o` to 6,4,6,4. `pd_rev_o` is 1 exactly during the 6 steps. `pd_i` is sampled at the end of the first 6 step and becomes the result.
- R7: Each step holds its outputs for H cycles, where H is `hold_i` latched at acceptance. A `hold_i` of 0 gives H = 1, and changing `hold_i` while busy has no effect.
- R8: `busy_o` rises in the cycle after a request is accepted and stays high for exactly (steps × H) cycles. A request made while busy is ignored: the sequence in flight is not altered, and no extra access follows.
- R9: `done_o` pulses for one cycle in the cycle after the last step, with `busy_o` low. For reads, `rdata_o` then holds the assembled byte until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, taken when not busy |
| wr_i | input | 1 | 1 = write, 0 = read |
| byte_mode_i | input | 1 | 0 = nibble-read style, 1 = byte style |
| cmd_sel_i | input | 1 | 0 = task-file registers, 1 = command-set registers |
| reg_i | input | 3 | Register number |
| wdata_i | input | 8 | Write value |
| hold_i | input | HOLD_W | Cycles per port step (0 means 1) |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read result |
| pd_o | output | 8 | Port data byte |
| ctl_o | output | 4 | Port control lines |
| pd_rev_o | output | 1 | Data lines turned around to input |
| pd_i | input | 8 | Port data lines as read |
| status_i | input | 8 | Port status byte |

## Verification
The bench compares every cycle of `pd_o`, `ctl_o` and `pd_rev_o` against an expected step list built from the handshake rules. This catches a reordered burst, a wrong address formula or a missing write round. The status and data inputs carry a different junk value on every step except the intended sampling step. A design that samples one step early or late, or swaps the nibble halves, returns a wrong byte. A hold of 0 and a change to the hold mid-transfer are both exercised, so a design that stalls on 0 or re-reads the hold live breaks the step timing. A request held high while busy checks that the design neither restarts nor queues a second access.

// File: rtl/pps_pkg.sv
// Package: shared step description and burst value helpers for the
// parallel-port register sequencer. Assumes 4 control lines, 8 data lines.
package pps_pkg;

    localparam int IDX_W    = 5;
    localparam int PRE_LEN  = 19;
    localparam logic [3:0] CTL_REST = 4'h4;

    typedef enum logic [1:0] {OP_RD_NIB, OP_RD_BYTE, OP_WRITE} op_e;
    typedef enum logic [1:0] {SMP_NONE, SMP_STAT_LO, SMP_STAT_HI, SMP_DATA} smp_e;

    typedef struct packed {
        logic       to_data;   // 1: value goes to data byte, 0: to control lines
        logic [7:0] val;
        logic       rev;       // data lines turned around (control steps only)
        smp_e       smp;       // capture at the end of this step
        logic       last;
    } step_t;

    // Six-step strobe burst: 5,D,5,D,5,4
    function automatic logic [3:0] burst_p(input logic [IDX_W-1:0] i);
        case (i)
            5'd1, 5'd3: burst_p = 4'hD;
            5'd5:       burst_p = 4'h4;
            default:    burst_p = 4'h5;
        endcase
    endfunction

    // Four-step strobe burst: 5,7,5,4
    function automatic logic [3:0] burst_q(input logic [IDX_W-1:0] i);
        case (i)
            5'd1:    burst_q = 4'h7;
            5'd3:    burst_q = 4'h4;
            default: burst_q = 4'h5;
        endcase
    endfunction

endpackage

// File: rtl/pps_step_rom.sv
// Step decoder: maps a step index plus the access description to the port
// action for that step. Purely combinational; assumes idx stays below the
// length of the selected sequence.
module pps_step_rom
    import pps_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  op_e              op,
    input  logic [7:0]       addr,
    input  logic [7:0]       wval,
    output step_t            st
);
    logic [IDX_W-1:0] j;

    // Decode one step of the prefix or of the op-specific tail
    always_comb begin
        st = '{to_data: 1'b0, val: 8'h00, rev: 1'b0, smp: SMP_NONE, last: 1'b0};
        j  = idx - IDX_W'(PRE_LEN);
        if (idx < IDX_W'(PRE_LEN)) begin
            if (idx == 5'd0) begin
                st.to_data = 1'b1; st.val = 8'h01;
            end else if (idx <= 5'd6) begin
                st.val = {4'h0, burst_p(idx - 5'd1)};
            end else if (idx == 5'd7) begin
                st.to_data = 1'b1; st.val = addr;
            end else if (idx <= 5'd11) begin
                st.val = {4'h0, burst_q(idx - 5'd8)};
            end else if (idx == 5'd12) begin
                st.to_data = 1'b1; st.val = 8'h00;
            end else begin
                st.val = {4'h0, burst_p(idx - 5'd13)};
            end
        end else begin
            case (op)
                OP_WRITE: begin
                    if (j == 5'd0 || j == 5'd5) begin
                        st.to_data = 1'b1; st.val = wval;
                    end else if (j < 5'd5) begin
                        st.val = {4'h0, burst_q(j - 5'd1)};
                    end else begin
                        st.val = {4'h0, burst_q(j - 5'd6)};
                    end
                    st.last = (j == 5'd9);
                end
                OP_RD_NIB: begin
                    st.val  = j[0] ? 8'h04 : 8'h06;
                    st.smp  = (j == 5'd0) ? SMP_STAT_LO :
                              (j == 5'd2) ? SMP_STAT_HI : SMP_NONE;
                    st.last = (j == 5'd7);
                end
                default: begin
                    st.val  = j[0] ? 8'h04 : 8'h06;
                    st.rev  = ~j[0];
                    st.smp  = (j == 5'd0) ? SMP_DATA : SMP_NONE;
                    st.last = (j == 5'd3);
                end
            endcase
        end
    end
endmodule

// File: rtl/pps_pacer.sv
// Step pacer: latches the per-step hold at start (0 becomes 1) and flags
// the last cycle of each step while the sequence runs.
module pps_pacer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              running,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              step_end
);
    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] cnt_q;

    // Latch hold length and count cycles within the current step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= HOLD_W'(1);
            cnt_q  <= '0;
        end else if (start) begin
            hold_q <= (hold_i == '0) ? HOLD_W'(1) : hold_i;
            cnt_q  <= '0;
        end else if (step_end) begin
            cnt_q  <= '0;
        end else if (running) begin
            cnt_q  <= cnt_q + HOLD_W'(1);
        end
    end

    assign step_end = running && (cnt_q == hold_q - HOLD_W'(1));
endmodule

// File: rtl/pps_join.sv
// Read capture: stores the two status samples and the data-line sample,
// and forms the result for the selected read style.
module pps_join
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap,
    input  smp_e       smp,
    input  logic       byte_style,
    input  logic [7:0] status_i,
    input  logic [7:0] pd_i,
    output logic [7:0] result
);
    logic [3:0] lo_q, hi_q;
    logic [7:0] byte_q;

    // Capture the sample selected by the step ending this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            byte_q <= '0;
        end else if (cap) begin
            case (smp)
                SMP_STAT_LO: lo_q   <= status_i[7:4];
                SMP_STAT_HI: hi_q   <= status_i[7:4];
                SMP_DATA:    byte_q <= pd_i;
                default: ;
            endcase
        end
    end

    assign result = byte_style ? byte_q : {hi_q, lo_q};
endmodule

// File: rtl/ppreg_seq.sv
// Top: accepts one register access, plays the port step sequence, returns
// read data with a done pulse. Assumes the external port buffer honours
// pd_rev_o for the data-line direction.
module ppreg_seq
    import pps_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic              byte_mode_i,
    input  logic              cmd_sel_i,
    input  logic [2:0]        reg_i,
    input  logic [7:0]        wdata_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [7:0]        rdata_o,
    output logic [7:0]        pd_o,
    output logic [3:0]        ctl_o,
    output logic              pd_rev_o,
    input  logic [7:0]        pd_i,
    input  logic [7:0]        status_i
);
    logic             busy_q, done_q, rev_q;
    logic [7:0]       pd_q, rdata_q, addr_q, wval_q;
    logic [3:0]       ctl_q;
    op_e              op_q, op_req, op_sel;
    logic [IDX_W-1:0] idx_q, nxt_idx;
    logic [7:0]       addr_req, addr_sel, wval_sel;
    logic             accept, step_end;
    step_t            cur_st, nxt_st;
    logic [7:0]       joined;

    assign accept   = req_i && !busy_q;
    assign op_req   = wr_i ? OP_WRITE : (byte_mode_i ? OP_RD_BYTE : OP_RD_NIB);
    assign addr_req = {3'b000, reg_i, 2'b01} + {7'b0, cmd_sel_i};

    // Choose the step to load next: step 0 of the new request, or the successor
    always_comb begin
        op_sel   = busy_q ? op_q   : op_req;
        addr_sel = busy_q ? addr_q : addr_req;
        wval_sel = busy_q ? wval_q : wdata_i;
        nxt_idx  = busy_q ? idx_q + IDX_W'(1) : '0;
    end

    pps_step_rom u_rom_cur (
        .idx (idx_q), .op (op_q), .addr (addr_q), .wval (wval_q), .st (cur_st)
    );

    pps_step_rom u_rom_nxt (
        .idx (nxt_idx), .op (op_sel), .addr (addr_sel), .wval (wval_sel), .st (nxt_st)
    );

    pps_pacer #(.HOLD_W (HOLD_W)) u_pacer (
        .clk (clk), .rst_n (rst_n), .start (accept), .running (busy_q),
        .hold_i (hold_i), .step_end (step_end)
    );

    pps_join u_join (
        .clk (clk), .rst_n (rst_n), .cap (step_end), .smp (cur_st.smp),
        .byte_style (op_q == OP_RD_BYTE), .status_i (status_i), .pd_i (pd_i),
        .result (joined)
    );

    // Sequence control: accept, advance steps, drive port, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            idx_q   <= '0;
            op_q    <= OP_RD_NIB;
            addr_q  <= '0;
            wval_q  <= '0;
            pd_q    <= '0;
            ctl_q   <= CTL_REST;
            rev_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept || (step_end && !cur_st.last)) begin
                idx_q <= nxt_idx;
                if (nxt_st.to_data) pd_q <= nxt_st.val;
                else begin
                    ctl_q <= nxt_st.val[3:0];
                    rev_q <= nxt_st.rev;
                end
            end
            if (accept) begin
                busy_q <= 1'b1;
                op_q   <= op_req;
                addr_q <= addr_req;
                wval_q <= wdata_i;
            end else if (step_end && cur_st.last) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                if (op_q != OP_WRITE) rdata_q <= joined;
            end
        end
    end

    assign busy_o   = busy_q;
    assign done_o   = done_q;
    assign rdata_o  = rdata_q;
    assign pd_o     = pd_q;
    assign ctl_o    = ctl_q;
    assign pd_rev_o = rev_q;
endmodule

// File: rtl/ppreg_seq_chk.sv
// Checker: temporal properties of the sequencer's port behaviour.
module ppreg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic [7:0] pd_o,
    input logic [3:0] ctl_o,
    input logic       pd_rev_o
);
    // R3
    first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (pd_o == 8'h01 && ctl_o == 4'h4));

    // R3
    rest_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ctl_o == 4'h4 && !pd_rev_o));

    // R6
    rev_only_six_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_rev_o |-> ctl_o == 4'h6);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8
    end_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
endmodule

bind ppreg_seq ppreg_seq_chk u_chk (
    .clk (clk), .rst_n (rst_n), .busy_o (busy_o), .done_o (done_o),
    .pd_o (pd_o), .ctl_o (ctl_o), .pd_rev_o (pd_rev_o)
);

// File: tb/ppreg_seq_test.sv
module ppreg_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 8;

    logic clk = 0, rst_n = 0, req = 0, wr = 0, bmode = 0, sel = 0;
    logic [2:0] rg = 0;
    logic [7:0] wd = 0, pd_in = 0, st_in = 0;
    logic [HW-1:0] hold = 1;
    logic busy, done, pd_rev;
    logic [7:0] rdata, pd;
    logic [3:0] ctl;

    int checks = 0, fails = 0;
    bit timed_out = 0;

    logic [7:0] e_d [0:31];
    logic [3:0] e_c [0:31];
    logic       e_r [0:31];
    int n_exp;
    logic [7:0] cur_d = 0;
    logic [3:0] cur_c = 4'h4;

    ppreg_seq #(.HOLD_W(HW)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .byte_mode_i(bmode),
        .cmd_sel_i(sel), .reg_i(rg), .wdata_i(wd), .hold_i(hold),
        .busy_o(busy), .done_o(done), .rdata_o(rdata), .pd_o(pd), .ctl_o(ctl),
        .pd_rev_o(pd_rev), .pd_i(pd_in), .status_i(st_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        timed_out = 1;
        fails++; checks++;
        $display("FAIL watchdog: run hung, actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic check(input bit ok, input string req_tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    task automatic put_d(input logic [7:0] v);
        cur_d = v; e_d[n_exp] = cur_d; e_c[n_exp] = cur_c; e_r[n_exp] = 0; n_exp++;
    endtask

    task automatic put_c(input logic [3:0] v, input logic r);
        cur_c = v; e_d[n_exp] = cur_d; e_c[n_exp] = cur_c; e_r[n_exp] = r; n_exp++;
    endtask

    task automatic burst_p_exp();
        put_c(4'h5,0); put_c(4'hD,0); put_c(4'h5,0); put_c(4'hD,0); put_c(4'h5,0); put_c(4'h4,0);
    endtask

    task automatic burst_q_exp();
        put_c(4'h5,0); put_c(4'h7,0); put_c(4'h5,0); put_c(4'h4,0);
    endtask

    // Build expected step list per R2..R6
    task automatic build(input bit w, input bit b, input bit s, input logic [2:0] r,
                         input logic [7:0] v);
        n_exp = 0;
        put_d(8'h01); burst_p_exp();
        put_d(8'(r) * 8'd4 + 8'd1 + 8'(s)); burst_q_exp();
        put_d(8'h00); burst_p_exp();
        if (w) begin
            put_d(v); burst_q_exp(); put_d(v); burst_q_exp();
        end else if (!b) begin
            for (int i = 0; i < 4; i++) begin put_c(4'h6,0); put_c(4'h4,0); end
        end else begin
            for (int i = 0; i < 2; i++) begin put_c(4'h6,1); put_c(4'h4,0); end
        end
    endtask

    // One access; intrude raises req mid-flight and changes hold
    task automatic xfer(input string tag, input bit w, input bit b, input bit s,
                        input logic [2:0] r, input logic [7:0] v, input logic [HW-1:0] h,
                        input logic [7:0] sa, input logic [7:0] sb, input logic [7:0] dv,
                        input bit intrude);
        int hh, bad, bad_k, busy_bad;
        logic [7:0] exp_rd;
        build(w, b, s, r, v);
        hh = (h == 0) ? 1 : int'(h);
        bad = 0; bad_k = -1; busy_bad = 0;
        @(negedge clk);
        req = 1; wr = w; bmode = b; sel = s; rg = r; wd = v; hold = h;
        @(posedge clk); @(negedge clk);
        req = 0;
        for (int k = 0; k < n_exp * hh; k++) begin
            int sidx;
            sidx = k / hh;
            if (pd !== e_d[sidx] || ctl !== e_c[sidx] || pd_rev !== e_r[sidx]) begin
                if (bad == 0) bad_k = k;
                bad++;
            end
            if (busy !== 1'b1 || done !== 1'b0) busy_bad++;
            if (intrude && k == 4) begin req = 1; rg = ~r; wd = ~v; hold = h + 8'd3; end
            if (intrude && k == 9) req = 0;
            st_in = (sidx == 19) ? sa : (sidx == 21) ? sb : {4'(sidx) ^ 4'hA, 4'h3};
            pd_in = (sidx == 19) ? dv : {~4'(sidx), 4'hC};
            @(posedge clk); @(negedge clk);
        end
        check(bad == 0, tag, $sformatf("port trace mismatch count (first at cycle %0d)", bad_k), bad, 0);
        check(busy_bad == 0, "R8", {tag, " busy high for whole access"}, busy_bad, 0);
        check(done === 1'b1 && busy === 1'b0, "R9", {tag, " done pulse after last step"},
              {done, busy}, 2'b10);
        if (!w) begin
            exp_rd = b ? dv : {sb[7:4], sa[7:4]};
            check(rdata === exp_rd, b ? "R6" : "R5", {tag, " read result"}, rdata, exp_rd);
        end
        @(posedge clk); @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R8", {tag, " no follow-on access"},
              {done, busy}, 2'b00);
        if (!w) check(rdata === exp_rd, "R9", {tag, " result held"}, rdata, exp_rd);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ctl === 4'h4 && pd === 8'h00 && pd_rev === 0 && busy === 0 && done === 0,
              "R1", "reset state", {pd, ctl, pd_rev, busy, done}, {8'h00, 4'h4, 3'b000});
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        xfer("R4 R2 write regfile", 1, 0, 0, 3'd6, 8'hA0, 8'd2, 0, 0, 0, 0);
        xfer("R4 R2 write cmdset hold0 R7", 1, 0, 1, 3'd7, 8'h5C, 8'd0, 0, 0, 0, 0);
        xfer("R4 byte-style write", 1, 1, 0, 3'd2, 8'hE1, 8'd1, 0, 0, 0, 0);
        xfer("R5 nibble read", 0, 0, 0, 3'd7, 8'h00, 8'd1, 8'h9F, 8'h30, 8'h00, 0);
        xfer("R5 nibble read hold3 R7", 0, 0, 1, 3'd0, 8'h00, 8'd3, 8'h6A, 8'hC5, 8'h00, 0);
        xfer("R6 byte read", 0, 1, 0, 3'd1, 8'h00, 8'd2, 8'h00, 8'h00, 8'h7E, 0);
        xfer("R6 byte read hold0", 0, 1, 1, 3'd5, 8'h00, 8'd0, 8'h00, 8'h00, 8'h81, 0);
        xfer("R8 R7 read with intruding request", 0, 0, 0, 3'd4, 8'h00, 8'd2, 8'hD2, 8'h4B, 8'h00, 1);
        xfer("R8 write with intruding request", 1, 0, 1, 3'd3, 8'h3C, 8'd1, 0, 0, 0, 1);
        if (!timed_out) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule